// File: doc/BRIEF.md
# Character Display Line Buffer

A small memory-mapped text buffer for a character display. The buffer holds eight bytes. A bus master reads or writes 1, 2, 4 or 8 bytes at any byte address, and the lane index wraps modulo eight. Every accepted write makes the block send one refresh line to a character sink over a valid/ready byte stream. A line is a carriage return followed by exactly eight characters. The line copies buffer bytes up to the first zero byte and pads the rest with spaces.

A write that lands while a line is still streaming updates the buffer at once and sets a pending flag. Exactly one more line follows the current one, however many writes arrived in between. Each line copies the buffer when it starts, so its content does not change while it streams. When the sink's connect input first rises after reset, the block sends a single space byte once.

Top module: `char_line_buffer`

## Requirements
- R1: After reset the buffer holds all zeros, `tx_valid` is low, and every read returns zero.
- R2: A write of N bytes (N in {1,2,4,8}, given on `bus_size` as the byte count) at address A stores data byte i, with i = 0 the least significant, into buffer slot (A + i) mod 8. Only the low three address bits are used.
- R3: Reading N bytes at A returns slot (A + i) mod 8 in byte i of `bus_rdata`, combinationally, with every byte at or above N equal to zero.
- R4: When `bus_size` is not 1, 2, 4 or 8, a write changes no slot and starts no line, and a read returns zero.
- R5: Every accepted write makes the block stream 0x0D and then exactly eight character bytes.
- R6: The character bytes follow the buffer from slot 0 upward until the first zero slot. That position and all later ones carry 0x20, so a zero byte is never sent.
- R7: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` does not change.
- R8: A write accepted while a line is streaming is visible to reads in the next cycle. One or more such writes cause exactly one further line after the current one, and that line shows the final buffer.
- R9: A line shows the buffer as it stood at the line's start, including the write that started it.
- R10: The first rising edge of `sink_conn` after reset causes one 0x20 byte and nothing more, and later edges cause nothing. If a line is due at the same time, the line goes first.
- R11: Reset re-arms the greeting, so the first connect edge after a new reset sends the space again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address; the low three bits select the start slot |
| bus_size | input | 4 | Access size in bytes |
| bus_wdata | input | 64 | Write data, byte 0 in bits 7:0 |
| bus_rdata | output | 64 | Read data for the current address and size |
| sink_conn | input | 1 | Sink connected level |
| tx_valid | output | 1 | Output byte valid |
| tx_ready | input | 1 | Sink accepts the byte |
| tx_data | output | 8 | Output byte |

## Verification
The assertions assume that `tx_ready` may drop in any cycle and that `bus_size` can take any of its sixteen codes. They also assume that `sink_conn` is a level the bench may toggle at any time. The stimulus draws random `tx_ready` backpressure, random start addresses, sizes that include illegal codes, and data bytes that are often zero, so lines end early at random points. Directed sequences cover writes landing during a line, a connect edge that coincides with a write, and a second reset.

// File: rtl/char_line_buffer.sv
module char_line_buffer #(
  parameter int ADDR_W = 16,
  parameter logic [7:0] CR_CHAR = 8'h0D,
  parameter logic [7:0] PAD_CHAR = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_size,
  input  logic [63:0]       bus_wdata,
  output logic [63:0]       bus_rdata,
  input  logic              sink_conn,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data
);
  localparam int NBYTES = 8;
  localparam int IDX_W = $clog2(NBYTES);
  localparam int POS_W = $clog2(NBYTES + 1);
  localparam logic [POS_W-1:0] LAST = POS_W'(NBYTES);

  logic [7:0] mem [NBYTES];
  logic [7:0] mem_nx [NBYTES];
  logic [7:0] snap [NBYTES];
  logic [POS_W-1:0] pos;
  logic busy, greeting, pend, greet_req, greeted, conn_q;
  logic size_ok, wr_ok, zero_seen;
  logic [IDX_W-1:0] base, k;
  logic [7:0] cur;

  assign size_ok = (bus_size != 4'd0) && ((bus_size & (bus_size - 4'd1)) == 4'd0)
                   && (32'(bus_size) <= NBYTES);
  assign wr_ok = bus_we && size_ok;
  assign base = bus_addr[IDX_W-1:0];

  always_comb begin
    mem_nx = mem;
    bus_rdata = '0;
    k = base;
    for (int i = 0; i < NBYTES; i++) begin
      k = base + IDX_W'(i);
      if (size_ok && i < 32'(bus_size)) begin
        bus_rdata[8*i +: 8] = mem[k];
        if (bus_we) mem_nx[k] = bus_wdata[8*i +: 8];
      end
    end
  end

  always_comb begin
    zero_seen = 1'b0;
    cur = PAD_CHAR;
    for (int i = 0; i < NBYTES; i++) begin
      if (snap[i] == 8'h00) zero_seen = 1'b1;
      if (pos == POS_W'(i + 1)) cur = zero_seen ? PAD_CHAR : snap[i];
    end
  end

  assign tx_valid = busy;
  assign tx_data  = greeting ? PAD_CHAR : (pos == '0 ? CR_CHAR : cur);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBYTES; i++) begin
        mem[i]  <= 8'h00;
        snap[i] <= 8'h00;
      end
      pos       <= '0;
      busy      <= 1'b0;
      greeting  <= 1'b0;
      pend      <= 1'b0;
      greet_req <= 1'b0;
      greeted   <= 1'b0;
      conn_q    <= 1'b0;
    end else begin
      mem    <= mem_nx;
      conn_q <= sink_conn;
      if (!busy) begin
        if (wr_ok || pend) begin
          busy     <= 1'b1;
          greeting <= 1'b0;
          pos      <= '0;
          snap     <= mem_nx;
          pend     <= 1'b0;
        end else if (greet_req) begin
          busy      <= 1'b1;
          greeting  <= 1'b1;
          greet_req <= 1'b0;
        end
      end else begin
        if (wr_ok) pend <= 1'b1;
        if (tx_ready) begin
          if (greeting || pos == LAST) busy <= 1'b0;
          else pos <= pos + 1'b1;
        end
      end
      if (sink_conn && !conn_q && !greeted) begin
        greet_req <= 1'b1;
        greeted   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/char_line_buffer_chk.sv
module char_line_buffer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  bus_size,
  input logic [63:0] bus_rdata,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [7:0]  tx_data
);
  logic legal;
  assign legal = (bus_size == 4'd1) || (bus_size == 4'd2) || (bus_size == 4'd4) || (bus_size == 4'd8);

  p_quiet_after_reset_r1: assert property (@(posedge clk) !rst_n |=> !tx_valid);

  p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_size == 4'd1 |-> bus_rdata[63:8] == 56'd0);

  p_upper_half_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_size == 4'd4 |-> bus_rdata[63:32] == 32'd0);

  p_bad_size_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !legal |-> bus_rdata == 64'd0);

  p_no_nul_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> tx_data != 8'h00);

  p_hold_under_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));
endmodule

bind char_line_buffer char_line_buffer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_size(bus_size), .bus_rdata(bus_rdata),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data)
);

// File: tb/char_line_buffer_tb.sv
module char_line_buffer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;

  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0, sink_conn = 1'b0, tx_ready = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [3:0] bus_size = 4'd8;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic tx_valid;
  logic [7:0] tx_data;

  int n_checks = 0, n_fail = 0;
  logic [7:0] mb [8];
  logic [7:0] rxq [$];
  logic [7:0] expq [$];
  bit rnd_ready = 0;

  char_line_buffer #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sink_conn(sink_conn), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run hung, actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    #1 tx_ready = rnd_ready ? 1'($urandom % 2) : 1'b1;
  end

  always @(negedge clk) if (rst_n && tx_valid && tx_ready) rxq.push_back(tx_data);

  function automatic bit legal(input logic [3:0] s);
    return s == 1 || s == 2 || s == 4 || s == 8;
  endfunction

  function automatic logic [63:0] model_read(input logic [2:0] a, input logic [3:0] s);
    logic [63:0] r = '0;
    if (legal(s)) for (int i = 0; i < int'(s); i++) r[8*i +: 8] = mb[3'(a + 3'(i))];
    return r;
  endfunction

  function automatic void model_write(input logic [2:0] a, input logic [3:0] s, input logic [63:0] d);
    if (legal(s)) for (int i = 0; i < int'(s); i++) mb[3'(a + 3'(i))] = d[8*i +: 8];
  endfunction

  function automatic void push_line();
    bit z = 0;
    expq.push_back(8'h0D);
    for (int i = 0; i < 8; i++) begin
      if (mb[i] == 8'h00) z = 1;
      expq.push_back(z ? 8'h20 : mb[i]);
    end
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] a, input logic [3:0] s, input logic [63:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = {$urandom} [ADDR_W-1:0]; bus_addr[2:0] = a;
    bus_size = s; bus_wdata = d;
    @(posedge clk);
    #2 bus_we = 1'b0;
    model_write(a, s, d);
  endtask

  task automatic drain();
    int quiet = 0;
    while (quiet < 4) begin
      @(negedge clk);
      quiet = tx_valid ? 0 : quiet + 1;
    end
  endtask

  task automatic check_stream(input string tag);
    check({tag, " length"}, 64'(rxq.size()), 64'(expq.size()));
    for (int i = 0; i < expq.size() && i < rxq.size(); i++)
      check(tag, 64'(rxq[i]), 64'(expq[i]));
    rxq.delete(); expq.delete();
  endtask

  task automatic check_reads(input string tag);
    for (int a = 0; a < 8; a++)
      for (int s = 0; s < 16; s++) begin
        @(negedge clk);
        bus_addr = ADDR_W'(a); bus_size = 4'(s);
        #1 check(tag, bus_rdata, model_read(3'(a), 4'(s)));
      end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    for (int i = 0; i < 8; i++) mb[i] = 8'h00;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 8; i++) mb[i] = 8'h00;
    repeat (3) @(negedge clk);
    #1 check("R1 valid in reset", 64'(tx_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", 64'(tx_valid), 0);
    check_reads("R1 reset reads zero");

    // R2 R5 R6: directed full write with a zero in the middle
    do_write(3'd0, 4'd8, 64'h4847_4600_4443_4241);
    push_line(); drain(); check_stream("R5 R6 line with early stop");
    check_reads("R3 read after full write");

    // R2 wrap: 4 bytes at slot 6
    do_write(3'd6, 4'd4, 64'h5A59_5857);
    push_line(); drain(); check_stream("R2 wrap line");
    check_reads("R2 R3 wrapped contents");

    // R4: illegal sizes ignored
    do_write(3'd2, 4'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    do_write(3'd5, 4'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    drain(); check_stream("R4 no line on bad size");
    check_reads("R4 buffer unchanged");

    // R8 R9: writes during a line collapse into one more line
    do_write(3'd0, 4'd8, 64'h3837_3635_3433_3231);
    push_line();
    do_write(3'd3, 4'd1, 64'h61);
    @(negedge clk); bus_addr = 3; bus_size = 1;
    #1 check("R8 read during line", bus_rdata, 64'h61);
    do_write(3'd7, 4'd2, 64'h6362);
    push_line(); drain(); check_stream("R8 R9 pending line");

    // R10: greeting once
    @(negedge clk); sink_conn = 1'b1;
    expq.push_back(8'h20); drain(); check_stream("R10 greeting");
    @(negedge clk); sink_conn = 1'b0;
    repeat (2) @(negedge clk); sink_conn = 1'b1;
    drain(); check_stream("R10 no second greeting");

    // R11 + R10 priority: reset re-arms, connect with a write
    @(negedge clk); sink_conn = 1'b0;
    do_reset();
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 0; bus_size = 4'd2; bus_wdata = 64'h4B4F; sink_conn = 1'b1;
    @(posedge clk); #2 bus_we = 1'b0;
    model_write(3'd0, 4'd2, 64'h4B4F);
    push_line(); expq.push_back(8'h20);
    drain(); check_stream("R11 R10 greeting after line");

    // R7 + random mix
    rnd_ready = 1;
    for (int it = 0; it < 60; it++) begin
      logic [63:0] d = {$urandom, $urandom};
      logic [3:0] s;
      int pick = $urandom % 6;
      s = pick == 0 ? 4'd1 : pick == 1 ? 4'd2 : pick == 2 ? 4'd4 : pick == 3 ? 4'd8 : 4'($urandom);
      for (int b = 0; b < 8; b++) if ($urandom % 4 == 0) d[8*b +: 8] = 8'h00;
      do_write(3'($urandom), s, d);
      if (legal(s)) push_line();
      drain(); check_stream("R5 R6 R7 random line");
      if (it % 10 == 0) check_reads("R2 R3 R4 random reads");
    end
    rnd_ready = 0;

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule